// File: doc/BRIEF.md
# Processor Power-Mode Controller

This block decides which parts of a processor core receive a clock. Software selects one of three static low-power levels (doze, nap, sleep) or turns on dynamic gating of idle execution units. It does this through a single mode write. The controller produces one clock enable per execution unit (integer, floating-point, branch, load/store and system-register by default), one enable for the bus-interface snoop logic and one enable for the time-base/decrementer clock.

A static request first waits in a drain phase until a quiesce input reports that no bus transaction is outstanding. The controller then enters the requested level. Doze stops the execution units but keeps snooping and the time base. Nap also stops snooping. Sleep stops every internal clock. An external interrupt, a decrementer interrupt (doze and nap only) or reset brings the core back to full power and clears the static request. When dynamic gating is on, each unit's enable drops while that unit reports idle. The enable rises again at once when a dispatch is pending for the unit, so the unit is running one cycle before the operation arrives.

Top module: `pmc_power_ctrl`

## Requirements
- R1: After reset, pwrState is 0 (run), dynamic gating is off, and every unit enable, busIfEn and timeBaseEn is 1.
- R2: pwrState codes are 0 run, 1 drain, 2 doze, 3 nap and 4 sleep. Static codes on modeWrStatic are 0 none, 1 doze, 2 nap and 3 sleep. A write in run with a nonzero static code moves to drain at the next edge. Drain holds while busQuiesce is low and no interrupt is present. At the first edge with busQuiesce high, drain moves to the requested level.
- R3: In doze, every unit enable is 0, and busIfEn and timeBaseEn are 1.
- R4: In nap, every unit enable is 0, busIfEn is 0 and timeBaseEn is 1.
- R5: In sleep, every unit enable, busIfEn and timeBaseEn is 0.
- R6: extIrq in drain, doze, nap or sleep returns to run at the next edge. The static request is cleared, so a later busQuiesce does not re-enter a low-power level. The dynamic-gating setting is kept.
- R7: decIrq returns doze and nap to run at the next edge, and aborts drain back to run. In sleep, decIrq has no effect.
- R8: In run or drain with dynamic gating on, unit i's enable is 0 exactly when unitIdle[i] is 1 and dispatchPending[i] is 0. The enable follows these inputs in the same cycle.
- R9: In run or drain with dynamic gating off, every unit enable is 1 whatever unitIdle shows.
- R10: A mode write outside run changes neither the state nor the dynamic-gating setting.
- R11: A write in run with static code 0 stays in run and only loads modeWrDyn as the dynamic-gating setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWrEn | input | 1 | Mode write strobe |
| modeWrStatic | input | 2 | Requested static level code |
| modeWrDyn | input | 1 | Dynamic-gating enable written with the mode |
| unitIdle | input | NUM_UNITS | Per-unit idle indication |
| dispatchPending | input | NUM_UNITS | Per-unit operation dispatched next cycle |
| busQuiesce | input | 1 | No outstanding bus transaction |
| extIrq | input | 1 | External interrupt wakeup |
| decIrq | input | 1 | Decrementer interrupt wakeup |
| unitClkEn | output | NUM_UNITS | Per-unit clock enable |
| busIfEn | output | 1 | Bus-interface snoop clock enable |
| timeBaseEn | output | 1 | Time-base/decrementer clock enable |
| pwrState | output | 3 | Current power state code |

## Verification
The bench builds the block with the default NUM_UNITS of 5. Every execution unit therefore gets its own idle and dispatch pattern, and a gating error that affects only one bit position stays visible. The five-bit width also lets random idle and pending vectors produce every mix of gated and running units across drain and run. Combined with rare interrupts and frequent mode writes, the random phase reaches interrupt-versus-quiesce collisions and writes attempted during every low-power level.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int STATE_W  = 3;
  localparam int STATIC_W = 2;

  typedef enum logic [STATE_W-1:0] {
    PS_RUN   = 3'd0,
    PS_DRAIN = 3'd1,
    PS_DOZE  = 3'd2,
    PS_NAP   = 3'd3,
    PS_SLEEP = 3'd4
  } pwr_state_e;

  typedef enum logic [STATIC_W-1:0] {
    SM_NONE  = 2'd0,
    SM_DOZE  = 2'd1,
    SM_NAP   = 2'd2,
    SM_SLEEP = 2'd3
  } static_mode_e;

  // strobes from the sequencer to the enable datapath
  typedef struct packed {
    logic loadMode;    // accept a software mode write
    logic clearReq;    // wakeup: drop the pending static level
    logic unitsAwake;  // execution units may run
    logic snoopOn;     // bus snoop clock on
    logic timeBaseOn;  // time base / decrementer clock on
  } pmc_strobe_t;

endpackage

// File: rtl/pmc_unit_gate.sv
module pmc_unit_gate (
  input  logic awake,
  input  logic dynEn,
  input  logic idle,
  input  logic pending,
  output logic clkEn
);
  // a pending dispatch overrides idle so the unit runs ahead of its operation
  always_comb begin
    clkEn = awake & (~dynEn | ~idle | pending);
  end
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeWrEn,
  input  logic [STATIC_W-1:0] modeWrStatic,
  input  logic [STATIC_W-1:0] reqMode,
  input  logic                busQuiesce,
  input  logic                extIrq,
  input  logic                decIrq,
  output pwr_state_e          state,
  output pmc_strobe_t         strobe
);

  pwr_state_e stateNext;
  pwr_state_e drainTarget;

  always_comb begin
    case (static_mode_e'(reqMode))
      SM_DOZE:  drainTarget = PS_DOZE;
      SM_NAP:   drainTarget = PS_NAP;
      SM_SLEEP: drainTarget = PS_SLEEP;
      default:  drainTarget = PS_RUN;
    endcase
  end

  always_comb begin
    stateNext = state;
    case (state)
      PS_RUN: begin
        if (modeWrEn && (modeWrStatic != SM_NONE)) stateNext = PS_DRAIN;
      end
      PS_DRAIN: begin
        if (extIrq || decIrq)  stateNext = PS_RUN;
        else if (busQuiesce)   stateNext = drainTarget;
      end
      PS_DOZE, PS_NAP: begin
        if (extIrq || decIrq)  stateNext = PS_RUN;
      end
      PS_SLEEP: begin
        if (extIrq)            stateNext = PS_RUN;
      end
      default:                 stateNext = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_RUN;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.loadMode   = modeWrEn && (state == PS_RUN);
    strobe.clearReq   = (state != PS_RUN) && (stateNext == PS_RUN);
    strobe.unitsAwake = (state == PS_RUN) || (state == PS_DRAIN);
    strobe.snoopOn    = (state != PS_NAP) && (state != PS_SLEEP);
    strobe.timeBaseOn = (state != PS_SLEEP);
  end

endmodule

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int NUM_UNITS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pmc_strobe_t          strobe,
  input  logic [STATIC_W-1:0]  modeWrStatic,
  input  logic                 modeWrDyn,
  input  logic [NUM_UNITS-1:0] unitIdle,
  input  logic [NUM_UNITS-1:0] dispatchPending,
  output logic [STATIC_W-1:0]  reqMode,
  output logic [NUM_UNITS-1:0] unitClkEn,
  output logic                 busIfEn,
  output logic                 timeBaseEn
);

  logic dynEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqMode <= SM_NONE;
      dynEn   <= 1'b0;
    end else if (strobe.loadMode) begin
      reqMode <= modeWrStatic;
      dynEn   <= modeWrDyn;
    end else if (strobe.clearReq) begin
      reqMode <= SM_NONE;
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    pmc_unit_gate u_gate (
      .awake  (strobe.unitsAwake),
      .dynEn  (dynEn),
      .idle   (unitIdle[u]),
      .pending(dispatchPending[u]),
      .clkEn  (unitClkEn[u])
    );
  end

  assign busIfEn    = strobe.snoopOn;
  assign timeBaseEn = strobe.timeBaseOn;

endmodule

// File: rtl/pmc_power_ctrl.sv
module pmc_power_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_UNITS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modeWrEn,
  input  logic [1:0]           modeWrStatic,
  input  logic                 modeWrDyn,
  input  logic [NUM_UNITS-1:0] unitIdle,
  input  logic [NUM_UNITS-1:0] dispatchPending,
  input  logic                 busQuiesce,
  input  logic                 extIrq,
  input  logic                 decIrq,
  output logic [NUM_UNITS-1:0] unitClkEn,
  output logic                 busIfEn,
  output logic                 timeBaseEn,
  output logic [2:0]           pwrState
);

  pwr_state_e          state;
  pmc_strobe_t         strobe;
  logic [STATIC_W-1:0] reqMode;

  pmc_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeWrEn    (modeWrEn),
    .modeWrStatic(modeWrStatic),
    .reqMode     (reqMode),
    .busQuiesce  (busQuiesce),
    .extIrq      (extIrq),
    .decIrq      (decIrq),
    .state       (state),
    .strobe      (strobe)
  );

  pmc_datapath #(.NUM_UNITS(NUM_UNITS)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .modeWrStatic   (modeWrStatic),
    .modeWrDyn      (modeWrDyn),
    .unitIdle       (unitIdle),
    .dispatchPending(dispatchPending),
    .reqMode        (reqMode),
    .unitClkEn      (unitClkEn),
    .busIfEn        (busIfEn),
    .timeBaseEn     (timeBaseEn)
  );

  assign pwrState = state;

endmodule

// File: rtl/pmc_power_ctrl_checker.sv
module pmc_power_ctrl_checker #(
  parameter int NUM_UNITS = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 modeWrEn,
  input logic [1:0]           modeWrStatic,
  input logic [NUM_UNITS-1:0] dispatchPending,
  input logic                 busQuiesce,
  input logic                 extIrq,
  input logic                 decIrq,
  input logic [NUM_UNITS-1:0] unitClkEn,
  input logic                 busIfEn,
  input logic                 timeBaseEn,
  input logic [2:0]           pwrState
);

  assert_run_to_drain_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd0 && modeWrEn && modeWrStatic != 2'd0) |=> pwrState == 3'd1);

  assert_drain_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd1 && !busQuiesce && !extIrq && !decIrq) |=> pwrState == 3'd1);

  assert_doze_outputs_R3: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 3'd2 |-> (unitClkEn == '0 && busIfEn && timeBaseEn));

  assert_nap_outputs_R4: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 3'd3 |-> (unitClkEn == '0 && !busIfEn && timeBaseEn));

  assert_sleep_outputs_R5: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 3'd4 |-> (unitClkEn == '0 && !busIfEn && !timeBaseEn));

  assert_ext_wake_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != 3'd0 && extIrq) |=> pwrState == 3'd0);

  assert_dec_wake_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((pwrState == 3'd2 || pwrState == 3'd3) && decIrq) |=> pwrState == 3'd0);

  assert_dec_sleep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd4 && !extIrq) |=> pwrState == 3'd4);

  assert_dispatch_awake_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState <= 3'd1) |-> ((dispatchPending & ~unitClkEn) == '0));

  assert_static_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState >= 3'd2 && !extIrq && !decIrq) |=> $stable(pwrState));

endmodule

bind pmc_power_ctrl pmc_power_ctrl_checker #(.NUM_UNITS(NUM_UNITS)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .modeWrEn       (modeWrEn),
  .modeWrStatic   (modeWrStatic),
  .dispatchPending(dispatchPending),
  .busQuiesce     (busQuiesce),
  .extIrq         (extIrq),
  .decIrq         (decIrq),
  .unitClkEn      (unitClkEn),
  .busIfEn        (busIfEn),
  .timeBaseEn     (timeBaseEn),
  .pwrState       (pwrState)
);

// File: tb/pmc_power_ctrl_bench.sv
module pmc_power_ctrl_bench;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rstN;
  logic         modeWrEn;
  logic [1:0]   modeWrStatic;
  logic         modeWrDyn;
  logic [N-1:0] unitIdle;
  logic [N-1:0] dispatchPending;
  logic         busQuiesce;
  logic         extIrq;
  logic         decIrq;
  logic [N-1:0] unitClkEn;
  logic         busIfEn;
  logic         timeBaseEn;
  logic [2:0]   pwrState;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  // reference model state
  int       mState;
  logic [1:0] mReq;
  logic     mDyn;

  always #4 clk = ~clk;

  pmc_power_ctrl #(.NUM_UNITS(N)) u_pmc_power_ctrl (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrStatic(modeWrStatic),
    .modeWrDyn(modeWrDyn), .unitIdle(unitIdle), .dispatchPending(dispatchPending),
    .busQuiesce(busQuiesce), .extIrq(extIrq), .decIrq(decIrq),
    .unitClkEn(unitClkEn), .busIfEn(busIfEn), .timeBaseEn(timeBaseEn),
    .pwrState(pwrState)
  );

  function automatic logic [N-1:0] expUnits(int st, logic dyn, logic [N-1:0] idle,
                                            logic [N-1:0] pend);
    if (st > 1) return '0;
    if (!dyn)   return '1;
    return ~idle | pend;
  endfunction

  function automatic string autoTag(int st, logic dyn);
    case (st)
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return dyn ? "R8" : "R9";
    endcase
  endfunction

  task automatic checkVal(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, advance model, wait next negedge
  task automatic step(logic wr, logic [1:0] ws, logic wd, logic [N-1:0] idle,
                      logic [N-1:0] pend, logic q, logic e, logic d, string tag);
    string t;
    modeWrEn = wr; modeWrStatic = ws; modeWrDyn = wd;
    unitIdle = idle; dispatchPending = pend;
    busQuiesce = q; extIrq = e; decIrq = d;
    #1;
    t = (tag == "") ? autoTag(mState, mDyn) : tag;
    checkVal(t, "pwrState", int'(pwrState), mState);
    checkVal(t, "unitClkEn", int'(unitClkEn), int'(expUnits(mState, mDyn, idle, pend)));
    checkVal(t, "busIfEn", int'(busIfEn), (mState == 3 || mState == 4) ? 0 : 1);
    checkVal(t, "timeBaseEn", int'(timeBaseEn), (mState == 4) ? 0 : 1);
    case (mState)
      0: if (wr) begin
           mDyn = wd; mReq = ws;
           if (ws != 2'd0) mState = 1;
         end
      1: if (e || d) begin mState = 0; mReq = 0; end
         else if (q) mState = 1 + int'(mReq);
      2, 3: if (e || d) begin mState = 0; mReq = 0; end
      4: if (e) begin mState = 0; mReq = 0; end
      default: mState = 0;
    endcase
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleCycle(logic q, string tag);
    step(1'b0, 2'd0, 1'b0, 5'b10101, 5'b00000, q, 1'b0, 1'b0, tag);
  endtask

  task automatic applyReset();
    rstN = 1'b0;
    mState = 0; mReq = 2'd0; mDyn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; modeWrEn = 0; modeWrStatic = 0; modeWrDyn = 0;
    unitIdle = '1; dispatchPending = '0; busQuiesce = 0; extIrq = 0; decIrq = 0;
    mState = 0; mReq = 0; mDyn = 0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;

    // R1: reset values, idle units still clocked with gating off
    step(1'b0, 2'd0, 1'b0, 5'b11111, 5'b00000, 1'b1, 1'b0, 1'b0, "R1");

    // R11: static code 0 only loads dynamic gating
    step(1'b1, 2'd0, 1'b1, 5'b00000, 5'b00000, 1'b1, 1'b0, 1'b0, "R11");
    // R8: idle units gated, pending one kept on
    step(1'b0, 2'd0, 1'b0, 5'b10110, 5'b00100, 1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 2'd0, 1'b0, 5'b11111, 5'b00000, 1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 2'd0, 1'b0, 5'b11111, 5'b10001, 1'b0, 1'b0, 1'b0, "R8");

    // R9: gating off keeps idle units running
    step(1'b1, 2'd0, 1'b0, 5'b00000, 5'b00000, 1'b0, 1'b0, 1'b0, "R9");
    step(1'b0, 2'd0, 1'b0, 5'b11111, 5'b00000, 1'b0, 1'b0, 1'b0, "R9");

    // R2: doze request waits for quiesce
    step(1'b1, 2'd1, 1'b1, 5'b00000, 5'b00000, 1'b0, 1'b0, 1'b0, "R2");
    idleCycle(1'b0, "R2");
    idleCycle(1'b0, "R2");
    idleCycle(1'b1, "R2");
    // R3: doze outputs
    idleCycle(1'b0, "R3");
    // R10: write during doze ignored (would clear gating and ask sleep)
    step(1'b1, 2'd3, 1'b0, 5'b11111, 5'b00000, 1'b1, 1'b0, 1'b0, "R10");
    idleCycle(1'b1, "R10");
    // R7: decrementer wakes doze
    step(1'b0, 2'd0, 1'b0, 5'b11111, 5'b00000, 1'b1, 1'b0, 1'b1, "R7");
    // R10: gating setting survived the ignored write; R6: no re-entry
    step(1'b0, 2'd0, 1'b0, 5'b11011, 5'b00000, 1'b1, 1'b0, 1'b0, "R10");
    idleCycle(1'b1, "R6");

    // R4: nap then external wake
    step(1'b1, 2'd2, 1'b0, 5'b00000, 5'b00000, 1'b1, 1'b0, 1'b0, "R2");
    idleCycle(1'b1, "R4");
    idleCycle(1'b1, "R4");
    step(1'b0, 2'd0, 1'b0, 5'b00000, 5'b00000, 1'b1, 1'b1, 1'b0, "R6");
    idleCycle(1'b1, "R6");

    // R5: sleep, decrementer ignored, external wakes
    step(1'b1, 2'd3, 1'b1, 5'b00000, 5'b00000, 1'b1, 1'b0, 1'b0, "R2");
    idleCycle(1'b1, "R5");
    step(1'b0, 2'd0, 1'b0, 5'b00000, 5'b00000, 1'b1, 1'b0, 1'b1, "R7");
    idleCycle(1'b1, "R7");
    step(1'b0, 2'd0, 1'b0, 5'b00000, 5'b00000, 1'b1, 1'b1, 1'b0, "R6");
    step(1'b0, 2'd0, 1'b0, 5'b01110, 5'b00010, 1'b1, 1'b0, 1'b0, "R6");

    // R7: decrementer aborts drain even with quiesce present
    step(1'b1, 2'd1, 1'b1, 5'b00000, 5'b00000, 1'b0, 1'b0, 1'b0, "R2");
    step(1'b0, 2'd0, 1'b0, 5'b00000, 5'b00000, 1'b1, 1'b0, 1'b1, "R7");
    idleCycle(1'b1, "R7");

    // R1: reset in sleep returns to run with gating off
    step(1'b1, 2'd3, 1'b1, 5'b00000, 5'b00000, 1'b1, 1'b0, 1'b0, "R2");
    idleCycle(1'b1, "R5");
    applyReset();
    step(1'b0, 2'd0, 1'b0, 5'b11111, 5'b00000, 1'b1, 1'b0, 1'b0, "R1");

    // random phase, tags chosen from model state
    for (int i = 0; i < 4000; i++) begin
      logic wr, wd, q, e, d;
      logic [1:0] ws;
      logic [N-1:0] idle, pend;
      wr   = ($urandom % 6) == 0;
      ws   = 2'($urandom % 4);
      wd   = 1'($urandom % 2);
      q    = ($urandom % 3) != 0;
      e    = ($urandom % 25) == 0;
      d    = ($urandom % 15) == 0;
      idle = N'($urandom);
      pend = N'($urandom) & N'($urandom);
      step(wr, ws, wd, idle, pend, q, e, d, "");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule